// File: doc/BRIEF.md
# PLL Holdover and Lock-Detect Controller

This block decides when a clock PLL goes into holdover, that is, when its charge pump is forced to high impedance and the loop coasts on the voltage already on its loop filter. Each phase detector comparison arrives as a one-cycle strobe with a flag. The flag says whether both edges landed inside the lock window. A run counter turns these results into a digital lock flag. The length of run it needs is set by a 2-bit select.

A hold sequencer combines the lock flag with three more inputs: a sampled lock-detect pin level, an external holdover request, and the status of the currently selected reference. It tracks whether holdover is armed. After every holdover episode, arming requires fresh lock and, when the pin comparator is in use, a charged pin. In automatic mode, holdover starts when lock is lost while the selected reference is absent. If lock is lost while a reference switchover is in progress, holdover lasts only until the next reference edge. In external mode, holdover follows the request pin. The charge-pump tristate control is a registered copy of the holdover state.

Top module: `pll_hold_ctrl`

## Requirements
- R1: The lock flag rises on the clock edge that samples the N-th consecutive in-window strobe (`pfd_valid`=1, `pfd_in_win`=1). N is 5, 16, 64 or 255 for `cfg_run_sel` codes 00, 01, 10 and 11. Clock cycles with `pfd_valid`=0 neither add to the run nor break it. The count saturates at N.
- R2: A strobe with `pfd_in_win`=0 clears the run, and the lock flag is low from the edge that samples it.
- R3: While `cfg_dld_off`=1, the run is held at zero and the lock flag stays low. In automatic mode no holdover can begin.
- R4: The pin is taken as charged when `cfg_pin_cmp_en`=0, and as `ld_pin_lvl` when it is 1. The sequencer arms only on an edge where lock is high and the pin is taken as charged.
- R5: After reset and after every holdover episode, the sequencer is unarmed. Losing lock while unarmed causes no holdover.
- R6: With `cfg_hold_en`=0 no holdover begins. If holdover is active, it ends on the next edge.
- R7: With `cfg_ext_mode`=1 and the sequencer armed, holdover begins on the edge that samples `ext_hold_req`=1. It ends on the edge that samples `ext_hold_req`=0.
- R8: With `cfg_ext_mode`=0 and the sequencer armed, holdover begins on the edge after the lock flag is low while `ref_ok`=0. It ends on the edge that samples `ref_ok`=1.
- R9: If lock is low while armed, `ref_ok`=1 and `ref_switching`=1, a brief holdover begins. It ends on the edge that samples `ref_edge`=1.
- R10: `cp_tristate` equals the holdover output of the previous clock cycle.
- R11: While reset is applied, and after it is released, lock, holdover and tristate are low and the sequencer is unarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pfd_valid | input | 1 | One-cycle strobe per phase detector comparison |
| pfd_in_win | input | 1 | Both edges were inside the lock window (valid with strobe) |
| ld_pin_lvl | input | 1 | Sampled lock-detect pin comparator level |
| ext_hold_req | input | 1 | External holdover request |
| ref_ok | input | 1 | Currently selected reference is present |
| ref_switching | input | 1 | Reference switchover in progress |
| ref_edge | input | 1 | Reference edge reached the phase detector |
| cfg_run_sel | input | 2 | Lock run-length select |
| cfg_dld_off | input | 1 | Disable digital lock detect |
| cfg_pin_cmp_en | input | 1 | Use the pin comparator level |
| cfg_ext_mode | input | 1 | 1 = external request, 0 = automatic |
| cfg_hold_en | input | 1 | Holdover enable for both modes |
| lock | output | 1 | Digital lock flag |
| holdover | output | 1 | Holdover active |
| cp_tristate | output | 1 | Charge-pump high-impedance control |

## Verification
The properties assume that every input is synchronous to the clock and that `pfd_valid` and `ref_edge` are single-cycle strobes. They also assume that the configuration bits change only while no strobe is present. The stimulus drives all inputs on the falling edge. It changes configuration between test phases, and only while the phase detector strobe is idle. A behavioural model of the run count and the hold sequence is compared against all three outputs on every cycle.

// File: rtl/pll_hold_pkg.sv
package pll_hold_pkg;
  typedef enum logic [1:0] {
    HS_WAIT  = 2'd0,
    HS_ARMED = 2'd1,
    HS_HOLD  = 2'd2,
    HS_SWH   = 2'd3
  } hold_state_e;
endpackage

// File: rtl/pll_rst_sync.sv
module pll_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
  parameter int unsigned LEN0 = 5,
  parameter int unsigned LEN1 = 16,
  parameter int unsigned LEN2 = 64,
  parameter int unsigned LEN3 = 255
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pfd_valid,
  input  logic       pfd_in_win,
  input  logic [1:0] run_sel,
  input  logic       dld_off,
  output logic       lock
);
  localparam int unsigned MAX01 = (LEN0 > LEN1) ? LEN0 : LEN1;
  localparam int unsigned MAX23 = (LEN2 > LEN3) ? LEN2 : LEN3;
  localparam int unsigned LMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CNT_W = $clog2(LMAX + 1);

  logic [CNT_W-1:0] tgt;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             lock_q, lock_d;

  always_comb begin
    unique case (run_sel)
      2'b00:   tgt = CNT_W'(LEN0);
      2'b01:   tgt = CNT_W'(LEN1);
      2'b10:   tgt = CNT_W'(LEN2);
      default: tgt = CNT_W'(LEN3);
    endcase
  end

  always_comb begin
    cnt_en = dld_off | pfd_valid;
    cnt_d  = cnt_q;
    if (dld_off)              cnt_d = '0;
    else if (pfd_valid) begin
      if (!pfd_in_win)        cnt_d = '0;
      else if (cnt_q >= tgt)  cnt_d = tgt;
      else                    cnt_d = cnt_q + 1'b1;
    end
    lock_d = !dld_off && (cnt_d == tgt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign lock = lock_q;
endmodule

// File: rtl/pll_hold_fsm.sv
module pll_hold_fsm
  import pll_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lock,
  input  logic        pin_lvl,
  input  logic        pin_cmp_en,
  input  logic        ext_mode,
  input  logic        hold_en,
  input  logic        dld_off,
  input  logic        ext_req,
  input  logic        ref_ok,
  input  logic        ref_switching,
  input  logic        ref_edge,
  output hold_state_e state,
  output logic        holdover,
  output logic        cp_tristate
);
  hold_state_e st_q, st_d;
  logic        pin_ok;
  logic        hold_d, cp_q;

  assign pin_ok = pin_cmp_en ? pin_lvl : 1'b1;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_WAIT: begin
        if (lock && pin_ok) st_d = HS_ARMED;
      end
      HS_ARMED: begin
        if (hold_en) begin
          if (ext_mode) begin
            if (ext_req) st_d = HS_HOLD;
          end else if (!dld_off && !lock) begin
            if (!ref_ok)            st_d = HS_HOLD;
            else if (ref_switching) st_d = HS_SWH;
          end
        end
      end
      HS_HOLD: begin
        if (!hold_en)                    st_d = HS_WAIT;
        else if (ext_mode && !ext_req)   st_d = HS_WAIT;
        else if (!ext_mode && ref_ok)    st_d = HS_WAIT;
      end
      default: begin
        if (!hold_en || ref_edge) st_d = HS_WAIT;
      end
    endcase
    hold_d = (st_q == HS_HOLD) || (st_q == HS_SWH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= HS_WAIT;
      cp_q <= 1'b0;
    end else begin
      st_q <= st_d;
      cp_q <= hold_d;
    end
  end

  assign state       = st_q;
  assign holdover    = (st_q == HS_HOLD) || (st_q == HS_SWH);
  assign cp_tristate = cp_q;
endmodule

// File: rtl/pll_hold_ctrl.sv
module pll_hold_ctrl
  import pll_hold_pkg::*;
#(
  parameter int unsigned LEN0       = 5,
  parameter int unsigned LEN1       = 16,
  parameter int unsigned LEN2       = 64,
  parameter int unsigned LEN3       = 255,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pfd_valid,
  input  logic       pfd_in_win,
  input  logic       ld_pin_lvl,
  input  logic       ext_hold_req,
  input  logic       ref_ok,
  input  logic       ref_switching,
  input  logic       ref_edge,
  input  logic [1:0] cfg_run_sel,
  input  logic       cfg_dld_off,
  input  logic       cfg_pin_cmp_en,
  input  logic       cfg_ext_mode,
  input  logic       cfg_hold_en,
  output logic       lock,
  output logic       holdover,
  output logic       cp_tristate
);
  logic        rst_n_s;
  hold_state_e hstate;

  pll_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  pll_lock_det #(.LEN0(LEN0), .LEN1(LEN1), .LEN2(LEN2), .LEN3(LEN3)) u_det (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .pfd_valid  (pfd_valid),
    .pfd_in_win (pfd_in_win),
    .run_sel    (cfg_run_sel),
    .dld_off    (cfg_dld_off),
    .lock       (lock)
  );

  pll_hold_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .lock          (lock),
    .pin_lvl       (ld_pin_lvl),
    .pin_cmp_en    (cfg_pin_cmp_en),
    .ext_mode      (cfg_ext_mode),
    .hold_en       (cfg_hold_en),
    .dld_off       (cfg_dld_off),
    .ext_req       (ext_hold_req),
    .ref_ok        (ref_ok),
    .ref_switching (ref_switching),
    .ref_edge      (ref_edge),
    .state         (hstate),
    .holdover      (holdover),
    .cp_tristate   (cp_tristate)
  );
endmodule

// File: rtl/pll_hold_ctrl_chk.sv
module pll_hold_ctrl_chk
  import pll_hold_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        pfd_valid,
  input logic        pfd_in_win,
  input logic        ext_hold_req,
  input logic        ref_edge,
  input logic        cfg_dld_off,
  input logic        cfg_ext_mode,
  input logic        cfg_hold_en,
  input logic        lock,
  input logic        holdover,
  input logic        cp_tristate,
  input hold_state_e hstate
);
  p_rise_needs_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(pfd_valid && pfd_in_win));

  p_miss_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pfd_valid && !pfd_in_win) |=> !lock);

  p_dld_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dld_off |=> !lock);

  p_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hstate == HS_WAIT) |=> !holdover);

  p_hold_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hold_en |=> !holdover);

  p_ext_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hstate == HS_ARMED && cfg_hold_en && cfg_ext_mode && ext_hold_req) |=> holdover);

  p_swh_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hstate == HS_SWH && ref_edge) |=> !holdover);

  p_cp_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    holdover |=> cp_tristate);

  p_cp_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !holdover |=> !cp_tristate);
endmodule

bind pll_hold_ctrl pll_hold_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pfd_valid    (pfd_valid),
  .pfd_in_win   (pfd_in_win),
  .ext_hold_req (ext_hold_req),
  .ref_edge     (ref_edge),
  .cfg_dld_off  (cfg_dld_off),
  .cfg_ext_mode (cfg_ext_mode),
  .cfg_hold_en  (cfg_hold_en),
  .lock         (lock),
  .holdover     (holdover),
  .cp_tristate  (cp_tristate),
  .hstate       (hstate)
);

// File: tb/pll_hold_ctrl_test.sv
module pll_hold_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pfd_valid, pfd_in_win, ld_pin_lvl, ext_hold_req;
  logic       ref_ok, ref_switching, ref_edge;
  logic [1:0] cfg_run_sel;
  logic       cfg_dld_off, cfg_pin_cmp_en, cfg_ext_mode, cfg_hold_en;
  logic       lock, holdover, cp_tristate;

  int total = 0;
  int bad   = 0;
  bit run   = 0;
  bit done  = 0;

  // behavioural model
  int m_cnt  = 0;
  bit m_lock = 0;
  int m_st   = 0; // 0 wait, 1 armed, 2 hold, 3 brief hold
  bit m_cp   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_hold_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pfd_valid(pfd_valid), .pfd_in_win(pfd_in_win),
    .ld_pin_lvl(ld_pin_lvl), .ext_hold_req(ext_hold_req), .ref_ok(ref_ok),
    .ref_switching(ref_switching), .ref_edge(ref_edge), .cfg_run_sel(cfg_run_sel),
    .cfg_dld_off(cfg_dld_off), .cfg_pin_cmp_en(cfg_pin_cmp_en),
    .cfg_ext_mode(cfg_ext_mode), .cfg_hold_en(cfg_hold_en),
    .lock(lock), .holdover(holdover), .cp_tristate(cp_tristate));

  function automatic int run_len(input logic [1:0] s);
    case (s)
      2'b00: return 5;
      2'b01: return 16;
      2'b10: return 64;
      default: return 255;
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (run) begin
      bit pin_ok, was_hold;
      int nst, tgt;
      pin_ok   = cfg_pin_cmp_en ? ld_pin_lvl : 1'b1;
      was_hold = (m_st >= 2);
      nst = m_st;
      if (m_st == 0) begin
        if (m_lock && pin_ok) nst = 1;
      end else if (m_st == 1) begin
        if (cfg_hold_en) begin
          if (cfg_ext_mode) begin
            if (ext_hold_req) nst = 2;
          end else if (!cfg_dld_off && !m_lock) begin
            if (!ref_ok) nst = 2;
            else if (ref_switching) nst = 3;
          end
        end
      end else if (m_st == 2) begin
        if (!cfg_hold_en || (cfg_ext_mode ? !ext_hold_req : ref_ok)) nst = 0;
      end else begin
        if (!cfg_hold_en || ref_edge) nst = 0;
      end
      tgt = run_len(cfg_run_sel);
      if (cfg_dld_off) m_cnt = 0;
      else if (pfd_valid) m_cnt = !pfd_in_win ? 0 : (m_cnt >= tgt ? tgt : m_cnt + 1);
      m_lock = !cfg_dld_off && (m_cnt == tgt);
      m_st = nst;
      m_cp = was_hold;
    end
  end

  always @(negedge clk) begin
    if (run) begin
      chk("R1 lock vs model", lock, m_lock);
      chk("R8 holdover vs model", holdover, m_st >= 2);
      chk("R10 cp_tristate vs model", cp_tristate, m_cp);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pfd(input int n, input logic win);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pfd_valid = 1'b1; pfd_in_win = win;
    end
    @(negedge clk);
    pfd_valid = 1'b0; pfd_in_win = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pfd_valid = 0; pfd_in_win = 0; ld_pin_lvl = 0; ext_hold_req = 0;
    ref_ok = 1; ref_switching = 0; ref_edge = 0;
    cfg_run_sel = 2'b00; cfg_dld_off = 0; cfg_pin_cmp_en = 0;
    cfg_ext_mode = 0; cfg_hold_en = 0;
    idle(3);
    chk("R11 lock in reset", lock, 1'b0);
    chk("R11 holdover in reset", holdover, 1'b0);
    chk("R11 cp in reset", cp_tristate, 1'b0);
    rst_n = 1'b1;
    idle(4);
    chk("R11 lock after reset", lock, 1'b0);
    chk("R11 holdover after reset", holdover, 1'b0);
    run = 1;

    // R1: five-cycle run
    pfd(4, 1); chk("R1 four hits no lock", lock, 1'b0);
    pfd(1, 1); chk("R1 fifth hit locks", lock, 1'b1);
    pfd(3, 1); chk("R1 saturated stays locked", lock, 1'b1);
    // R2
    pfd(1, 0); chk("R2 miss drops lock", lock, 1'b0);
    // R1 gaps do not break run
    pfd(3, 1); idle(3); pfd(2, 1); chk("R1 gaps keep run", lock, 1'b1);
    pfd(1, 0);
    // other run lengths
    cfg_run_sel = 2'b01; idle(1);
    pfd(15, 1); chk("R1 sel01 15 hits", lock, 1'b0);
    pfd(1, 1);  chk("R1 sel01 16 hits", lock, 1'b1);
    pfd(1, 0);
    cfg_run_sel = 2'b10; idle(1);
    pfd(63, 1); chk("R1 sel10 63 hits", lock, 1'b0);
    pfd(1, 1);  chk("R1 sel10 64 hits", lock, 1'b1);
    pfd(1, 0);
    cfg_run_sel = 2'b11; idle(1);
    pfd(200, 1); pfd(1, 0); chk("R2 miss mid run", lock, 1'b0);
    pfd(254, 1); chk("R1 sel11 254 hits", lock, 1'b0);
    pfd(1, 1);   chk("R1 sel11 255 hits", lock, 1'b1);
    pfd(1, 0);
    cfg_run_sel = 2'b00; idle(1);
    // R3
    cfg_dld_off = 1; idle(1);
    pfd(10, 1); chk("R3 disabled detector no lock", lock, 1'b0);
    cfg_dld_off = 0; idle(1);

    // R8 automatic holdover
    cfg_hold_en = 1; ref_ok = 1; idle(1);
    pfd(5, 1); idle(2);
    ref_ok = 0; pfd(1, 0); idle(2);
    chk("R8 auto holdover entered", holdover, 1'b1);
    chk("R10 cp tristated", cp_tristate, 1'b1);
    ref_ok = 1; idle(1);
    chk("R8 auto holdover left", holdover, 1'b0);
    chk("R10 cp still tristate one cycle", cp_tristate, 1'b1);
    idle(1);
    chk("R10 cp released", cp_tristate, 1'b0);
    // R5 unarmed after episode
    ref_ok = 0; idle(4);
    chk("R5 no holdover while unarmed", holdover, 1'b0);
    ref_ok = 1; idle(1);

    // R4 comparator gating
    cfg_pin_cmp_en = 1; ld_pin_lvl = 0; idle(1);
    pfd(5, 1); idle(2);
    ref_ok = 0; pfd(1, 0); idle(3);
    chk("R4 uncharged pin blocks arming", holdover, 1'b0);
    ref_ok = 1; ld_pin_lvl = 1; idle(1);
    pfd(5, 1); idle(2);
    ref_ok = 0; pfd(1, 0); idle(2);
    chk("R4 charged pin arms", holdover, 1'b1);
    ref_ok = 1; idle(2);
    cfg_pin_cmp_en = 0; ld_pin_lvl = 0;

    // R7 external mode
    cfg_ext_mode = 1; pfd(5, 1); idle(2);
    ext_hold_req = 1; idle(1);
    chk("R7 external request holds", holdover, 1'b1);
    idle(3); chk("R7 holds while requested", holdover, 1'b1);
    ext_hold_req = 0; idle(1);
    chk("R7 release ends holdover", holdover, 1'b0);
    // R6 disable
    cfg_hold_en = 0; pfd(5, 1); idle(2);
    ext_hold_req = 1; idle(3);
    chk("R6 disabled blocks external", holdover, 1'b0);
    cfg_hold_en = 1; idle(1);
    chk("R6 enable with request holds", holdover, 1'b1);
    cfg_hold_en = 0; idle(1);
    chk("R6 disable ends holdover", holdover, 1'b0);
    ext_hold_req = 0; cfg_hold_en = 1; cfg_ext_mode = 0; idle(2);

    // R9 brief holdover during switchover
    ref_ok = 1; pfd(5, 1); idle(2);
    ref_switching = 1; pfd(1, 0);
    chk("R9 not yet holding", holdover, 1'b0);
    idle(1);
    chk("R9 brief holdover entered", holdover, 1'b1);
    chk("R10 cp lags by one", cp_tristate, 1'b0);
    idle(4);
    chk("R9 held until reference edge", holdover, 1'b1);
    ref_edge = 1; idle(1); ref_edge = 0;
    chk("R9 reference edge ends holdover", holdover, 1'b0);
    ref_switching = 0; idle(3);

    run = 0; done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule